// File: doc/BRIEF.md
# Overvoltage Low-Side Force Controller

This block is the digital decision logic that sits behind the output-voltage comparators of a two-channel buck controller. For each channel it decides when the low-side switch must be forced on to discharge an output that has gone too high, and when that force may be released. It also decides when an overvoltage has lasted long enough to count as a fault. Once that happens it keeps the channel's fault latched until the supply power-on reset. The latched flag has three uses: it holds the high-side drive off, it holds the shared enable/fault line low, and it reports the fault.

Each channel has three comparator flags: above 120%, above 113% and below 87% of the target voltage. It also has the sensed level of the channel's enable/fault line. All of these pass through a two-flop synchronizer before any logic uses them. A static mode input selects between two operating modes. In independent mode each channel reacts only to its own monitor. In multiphase mode an overvoltage on either channel latches every channel in the same cycle.

Top module: `ovp_lsforce_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released, `lsforce_o` and `ov_latched_o` are all zero.
- R2: Every comparator flag and every enable sense input passes through two flip-flop stages. An input applied before rising edge k can first change an output at rising edge k+2, and not before.
- R3: A channel's `lsforce_o` bit goes high when two conditions hold on the same cycle. The channel's effective enable must be low, and its above-113% flag must be 1 while its below-87% flag is 0.
- R4: A channel's `lsforce_o` bit goes low when its below-87% flag is 1. This release takes priority over the set condition.
- R5: When the below-87% flag is 0 and the set condition is false, `lsforce_o` keeps its value. This includes the case where the enable line returns high.
- R6: The above-120% flag, after synchronization, must be 1 on three consecutive clock cycles before an overvoltage event is declared. A single cycle at 0 restarts the count.
- R7: An overvoltage event sets that channel's `ov_latched_o` bit. The bit stays set whatever happens on the enable, hysteresis or 120% inputs, and only `rst_n` clears it.
- R8: A channel whose `ov_latched_o` bit is set treats its enable as low. Its `lsforce_o` therefore goes high once the above-113% flag is 1, even while the sensed enable line is high.
- R9: With `multiphase_i` = 1, an overvoltage event on any channel sets every `ov_latched_o` bit at the same clock edge.
- R10: With `multiphase_i` = 0, an overvoltage event on one channel leaves the other channels' `ov_latched_o` bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Supply power-on reset, active low, asynchronous |
| multiphase_i | input | 1 | 1 = multiphase mode, 0 = independent channels (static strap) |
| above_ovp_i | input | NUM_CH | Per channel: output above 120% of target |
| above_hi_i | input | NUM_CH | Per channel: output above 113% of target |
| below_lo_i | input | NUM_CH | Per channel: output below 87% of target |
| en_sense_i | input | NUM_CH | Per channel: sensed enable/fault line level, 1 = high |
| lsforce_o | output | NUM_CH | Per channel: force the low-side switch on |
| ov_latched_o | output | NUM_CH | Per channel: overvoltage latched (high-side off, enable held low) |

## Verification
The bench builds the block with its defaults: two channels, two synchronizer stages and a persistence of three cycles. With these values the full pipeline latency and the persistence window are short enough to hit exactly with directed stimulus. The bench places a 120% pulse that is one cycle too short, and a pulse gap that restarts the count. The two-channel width lets one channel trip while the other is watched. That makes both the shared latching of multiphase mode and the isolation of independent mode observable at the ports.

// File: rtl/ovp_lsf_pkg.sv
package ovp_lsf_pkg;

    typedef enum logic {
        MODE_INDEP = 1'b0,
        MODE_MULTI = 1'b1
    } phase_mode_e;

endpackage

// File: rtl/ovp_lsf_sync.sv
module ovp_lsf_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ovp_lsf_persist.sv
module ovp_lsf_persist #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic hit_o
);

    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!level_i)              cnt_d = '0;
        else if (cnt_q == CNT_TOP) cnt_d = cnt_q;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // This cycle is the CYCLES-th consecutive one with the level high.
    assign hit_o = level_i && (cnt_q == CNT_TOP);

endmodule

// File: rtl/ovp_lsforce_ctrl.sv
module ovp_lsforce_ctrl
    import ovp_lsf_pkg::*;
#(
    parameter int NUM_CH         = 2,
    parameter int SYNC_STAGES    = 2,
    parameter int PERSIST_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              multiphase_i,
    input  logic [NUM_CH-1:0] above_ovp_i,
    input  logic [NUM_CH-1:0] above_hi_i,
    input  logic [NUM_CH-1:0] below_lo_i,
    input  logic [NUM_CH-1:0] en_sense_i,
    output logic [NUM_CH-1:0] lsforce_o,
    output logic [NUM_CH-1:0] ov_latched_o
);

    localparam int RAW_W = 4 * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0] frc;
        logic [NUM_CH-1:0] ovl;
    } ctl_state_t;

    logic [RAW_W-1:0]  raw_in, raw_s;
    logic [NUM_CH-1:0] ovp_s, hi_s, lo_s, en_s;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] en_low;
    phase_mode_e       mode;
    ctl_state_t        st_d, st_q;

    assign raw_in = {en_sense_i, below_lo_i, above_hi_i, above_ovp_i};

    ovp_lsf_sync #(
        .W      (RAW_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (raw_s)
    );

    assign ovp_s = raw_s[0*NUM_CH +: NUM_CH];
    assign hi_s  = raw_s[1*NUM_CH +: NUM_CH];
    assign lo_s  = raw_s[2*NUM_CH +: NUM_CH];
    assign en_s  = raw_s[3*NUM_CH +: NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ovp_lsf_persist #(
            .CYCLES (PERSIST_CYCLES)
        ) u_persist (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (ovp_s[g]),
            .hit_o   (hit[g])
        );
    end

    assign mode = phase_mode_e'(multiphase_i);

    always_comb begin
        st_d   = st_q;
        en_low = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            // overvoltage latch: sticky until power-on reset
            if (mode == MODE_MULTI) begin
                if (|hit) st_d.ovl[i] = 1'b1;
            end else begin
                if (hit[i]) st_d.ovl[i] = 1'b1;
            end
            // latched fault holds the enable line low
            en_low[i] = !en_s[i] || st_q.ovl[i];
            // low-side force with 113% / 87% hysteresis, release wins
            if (lo_s[i])                  st_d.frc[i] = 1'b0;
            else if (en_low[i] && hi_s[i]) st_d.frc[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lsforce_o    = st_q.frc;
    assign ov_latched_o = st_q.ovl;

endmodule

// File: rtl/ovp_lsforce_chk.sv
module ovp_lsforce_chk #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              multiphase_i,
    input logic [NUM_CH-1:0] above_hi_i,
    input logic [NUM_CH-1:0] below_lo_i,
    input logic [NUM_CH-1:0] lsforce_o,
    input logic [NUM_CH-1:0] ov_latched_o
);

    localparam int LAT = SYNC_STAGES + 1;

    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_latched_o != '0) |=> ((ov_latched_o & $past(ov_latched_o)) == $past(ov_latched_o))); // R7

    AST_MULTI_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(multiphase_i) && (ov_latched_o != $past(ov_latched_o))) |-> (ov_latched_o == '1)); // R9

    for (genvar g = 0; g < NUM_CH; g++) begin : g_a
        AST_FORCE_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lsforce_o[g]) |-> $past(above_hi_i[g], LAT)); // R3
        AST_FORCE_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lsforce_o[g]) |-> $past(below_lo_i[g], LAT)); // R4
    end

endmodule

bind ovp_lsforce_ctrl ovp_lsforce_chk #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .multiphase_i (multiphase_i),
    .above_hi_i   (above_hi_i),
    .below_lo_i   (below_lo_i),
    .lsforce_o    (lsforce_o),
    .ov_latched_o (ov_latched_o)
);

// File: tb/ovp_lsforce_ctrl_test.sv
`timescale 1ns/1ps
module ovp_lsforce_ctrl_test;

    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mp = 1'b0;
    logic [N-1:0] ovp = '0, hi = '0, lo = '0, en = '1;
    logic [N-1:0] frc, ovl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ovp_lsforce_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .multiphase_i (mp),
        .above_ovp_i  (ovp),
        .above_hi_i   (hi),
        .below_lo_i   (lo),
        .en_sense_i   (en),
        .lsforce_o    (frc),
        .ov_latched_o (ovl)
    );

    // Behavioural reference: inputs seen by the decision logic lag two edges
    logic [4*N-1:0] hist[$];
    int             run[N];
    logic [N-1:0]   m_frc = '0, m_ov = '0;

    always @(posedge clk) begin
        logic [4*N-1:0] u;
        logic [N-1:0]   h, old_ov;
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < N; i++) run[i] = 0;
            m_frc = '0;
            m_ov  = '0;
        end else begin
            hist.push_back({en, lo, hi, ovp});
            if (hist.size() > 3) void'(hist.pop_front());
            u = (hist.size() == 3) ? hist[0] : '0;
            old_ov = m_ov;
            for (int i = 0; i < N; i++) begin
                h[i] = u[i] && (run[i] >= 2);
                run[i] = u[i] ? ((run[i] >= 2) ? 2 : run[i] + 1) : 0;
            end
            for (int i = 0; i < N; i++) begin
                if (mp ? (h != '0) : h[i]) m_ov[i] = 1'b1;
                if (u[2*N+i]) m_frc[i] = 1'b0;
                else if ((!u[3*N+i] || old_ov[i]) && u[N+i]) m_frc[i] = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (frc !== m_frc) begin
                errors++;
                $display("FAIL R3 model lsforce: actual %b expected %b at %0t", frc, m_frc, $time);
            end
            checks++;
            if (ovl !== m_ov) begin
                errors++;
                $display("FAIL R7 model ov_latched: actual %b expected %b at %0t", ovl, m_ov, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        chk("R1 force in reset", frc, 2'b00);
        chk("R1 ov in reset", ovl, 2'b00);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 force after reset", frc, 2'b00);
        chk("R1 ov after reset", ovl, 2'b00);

        // set path and latency
        en = 2'b10; hi = 2'b01;
        cyc(2);
        chk("R2 force not before third edge", frc, 2'b00);
        cyc(1);
        chk("R3 force set on enable low and 113%", frc, 2'b01);
        hi = 2'b00;
        cyc(6);
        chk("R5 force held between thresholds", frc, 2'b01);
        en = 2'b11;
        cyc(6);
        chk("R5 enable high does not release", frc, 2'b01);
        lo = 2'b01;
        cyc(2);
        chk("R2 release not yet visible", frc, 2'b01);
        cyc(1);
        chk("R4 release below 87%", frc, 2'b00);
        lo = 2'b00;

        // release priority
        en = 2'b10; hi = 2'b01; lo = 2'b01;
        cyc(6);
        chk("R4 release has priority", frc, 2'b00);
        hi = 2'b00; lo = 2'b00; en = 2'b11;
        cyc(4);

        // persistence
        ovp = 2'b01; cyc(2);
        ovp = 2'b00; cyc(1);
        ovp = 2'b01; cyc(2);
        ovp = 2'b00; cyc(6);
        chk("R6 interrupted 120% ignored", ovl, 2'b00);
        ovp = 2'b01; cyc(3);
        ovp = 2'b00; cyc(1);
        chk("R6 no latch before third cycle", ovl, 2'b00);
        cyc(1);
        chk("R6 latch after three cycles", ovl, 2'b01);
        chk("R10 other channel untouched", ovl & 2'b10, 2'b00);

        hi = 2'b01;
        cyc(3);
        chk("R8 latched channel forces with enable high", frc, 2'b01);
        en = 2'b10; cyc(2);
        en = 2'b11; cyc(5);
        chk("R7 latch survives enable activity", ovl, 2'b01);
        hi = 2'b00; lo = 2'b01;
        cyc(3);
        chk("R4 release after latch", frc, 2'b00);
        chk("R7 latch survives release", ovl, 2'b01);
        lo = 2'b00;

        // power-on reset clears the latch
        rst_n = 1'b0;
        cyc(2);
        chk("R7 reset clears latch", ovl, 2'b00);
        rst_n = 1'b1;
        mp = 1'b1;
        cyc(2);
        ovp = 2'b10; cyc(3);
        ovp = 2'b00; cyc(1);
        chk("R9 none latched early", ovl, 2'b00);
        cyc(1);
        chk("R9 both latch together", ovl, 2'b11);
        hi = 2'b11;
        cyc(3);
        chk("R8 both forced in multiphase", frc, 2'b11);
        hi = 2'b00;

        // independent channel 1
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        mp = 1'b0;
        cyc(2);
        ovp = 2'b10; cyc(3);
        ovp = 2'b00; cyc(2);
        chk("R10 only own channel latches", ovl, 2'b10);
        cyc(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule